// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

A purely combinational arithmetic and logic unit for an accumulator-style 8-bit processor. The caller supplies a 4-bit operation code, the accumulator (or index register) operand, the memory operand, and the incoming carry and decimal-mode bits. The unit returns the result byte, the negative, zero, carry and overflow flags, and a 4-bit write-back mask that says which of those flags the operation owns.

Addition and subtraction run in plain binary or, when the decimal bit is set, on packed two-digit decimal values. Subtraction treats carry as an inverted borrow. Compare and bit-test leave the accumulator value untouched and only produce flags. Shifts and rotates use the carry as a ninth bit. Decode, operand fetch, register storage and memory access live outside this block.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add): res_o = (acc_i + mem_i + carry_i) mod 256, c_o = carry out of bit 7, v_o = 1 when acc_i and mem_i share bit 7 and res_o bit 7 differs from it; upd_o = 4'b1111 (mask bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V).
- R2: Code 1 (subtract), decimal clear: res_o = (acc_i - mem_i - (1 - carry_i)) mod 256, c_o = 1 exactly when no borrow occurs, v_o = signed overflow of acc_i + ~mem_i + carry_i; upd_o = 4'b1111.
- R3: Code 0 with dec_i = 1: each decimal digit, low first, is summed with the incoming digit carry; a digit sum above 9 is corrected by adding 6 and carries into the next digit; c_o is the carry out of the high digit.
- R4: Code 1 with dec_i = 1: each digit is subtracted with the incoming digit borrow (low digit borrow = 1 - carry_i); a negative digit is corrected by subtracting 6 and borrows from the next digit; c_o = 1 when the high digit does not borrow.
- R5: In decimal mode v_o equals the binary-mode v_o for the same inputs, while n_o and z_o follow the corrected result.
- R6: Codes 2, 3, 4 give acc_i AND, OR, XOR mem_i; upd_o = 4'b1100.
- R7: Codes 7, 8, 13 give mem_i + 1, mem_i - 1 (both wrapping) and mem_i unchanged (load/transfer); upd_o = 4'b1100.
- R8: Code 9 shifts acc_i left bringing in 0 with old bit 7 to c_o; code 10 shifts right bringing in 0 with old bit 0 to c_o; upd_o = 4'b1110.
- R9: Code 11 rotates acc_i left with carry_i into bit 0 and old bit 7 to c_o; code 12 rotates right with carry_i into bit 7 and old bit 0 to c_o; upd_o = 4'b1110.
- R10: Code 5 (compare): res_o = acc_i, n_o and z_o from acc_i - mem_i, c_o = (acc_i >= mem_i), carry_i and dec_i have no effect; upd_o = 4'b1110.
- R11: Code 6 (bit test): res_o = acc_i, z_o = ((acc_i & mem_i) == 0), n_o = mem_i bit 7, v_o = mem_i bit 6; upd_o = 4'b1101.
- R12: For every code other than 5 and 6 that updates N and Z, n_o = res_o bit 7 and z_o = (res_o == 0).
- R13: Every flag whose mask bit is 0 is driven 0.
- R14: Codes 14 and 15 are unassigned: res_o = acc_i, upd_o = 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator or index register operand |
| mem_i | input | 8 | Memory operand |
| carry_i | input | 1 | Incoming carry flag |
| dec_i | input | 1 | Decimal-mode flag |
| res_o | output | 8 | Result byte |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |
| upd_o | output | 4 | Flag write-back mask {N, Z, C, V} |

## Verification
The hardest case is the decimal digit chain where a corrected low digit passes a carry or borrow into a high digit that then needs its own correction, for example 0x99 + 0x01 or 0x00 - 0x01, which wrap through zero and flip the carry. The bench reaches these with directed operand pairs chosen so that each digit sits at 9 or 0, with carry_i set both ways, and then sweeps every operation code against pseudo-random operands in both modes so that digit corrections occur in both positions and in combination.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_BIT  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_PASS = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  localparam logic [3:0] MASK_ALL  = 4'b1111;
  localparam logic [3:0] MASK_NZ   = 4'b1100;
  localparam logic [3:0] MASK_NZC  = 4'b1110;
  localparam logic [3:0] MASK_NZV  = 4'b1101;
  localparam logic [3:0] MASK_NONE = 4'b0000;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  input  logic         dec_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   bin_full;
  logic [W-1:0] dec_sum;
  // digit chain: carry when adding, borrow when subtracting
  logic [DIGITS:0] chain;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign bin_full = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign ovf_o    = (a_i[W-1] == b_eff[W-1]) && (bin_full[W-1] != a_i[W-1]);
  assign chain[0] = sub_i ? ~cin_i : cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] da, db;
    logic [5:0] t_add, t_sub;
    logic       add_c, sub_b;
    assign da    = a_i[4*g +: 4];
    assign db    = b_i[4*g +: 4];
    assign t_add = {2'b00, da} + {2'b00, db} + {5'b0, chain[g]};
    assign t_sub = {2'b00, da} - {2'b00, db} - {5'b0, chain[g]};
    assign add_c = t_add > 6'd9;
    assign sub_b = t_sub[5];
    always_comb begin
      if (sub_i) dec_sum[4*g +: 4] = sub_b ? (t_sub[3:0] - 4'd6) : t_sub[3:0];
      else       dec_sum[4*g +: 4] = add_c ? (t_add[3:0] + 4'd6) : t_add[3:0];
    end
    assign chain[g+1] = sub_i ? sub_b : add_c;
  end

  always_comb begin
    if (dec_i) begin
      sum_o  = dec_sum;
      cout_o = sub_i ? ~chain[DIGITS] : chain[DIGITS];
    end else begin
      sum_o  = bin_full[W-1:0];
      cout_o = bin_full[W];
    end
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op_i)
      OP_AND, OP_BIT: res_o = a_i & m_i;
      OP_OR:          res_o = a_i | m_i;
      OP_XOR:         res_o = a_i ^ m_i;
      OP_INC:         res_o = m_i + ONE;
      OP_DEC:         res_o = m_i - ONE;
      OP_PASS:        res_o = m_i;
      default:        res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic fill_lo, fill_hi;

  // rotates feed carry in, plain shifts feed zero
  assign fill_lo = (op_i == OP_ROL) ? cin_i : 1'b0;
  assign fill_hi = (op_i == OP_ROR) ? cin_i : 1'b0;

  always_comb begin
    unique case (op_i)
      OP_SHL, OP_ROL: begin
        res_o  = {a_i[W-2:0], fill_lo};
        cout_o = a_i[W-1];
      end
      OP_SHR, OP_ROR: begin
        res_o  = {fill_hi, a_i[W-1:1]};
        cout_o = a_i[0];
      end
      default: begin
        res_o  = a_i;
        cout_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  input  logic         carry_i,
  input  logic         dec_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic [3:0]   upd_o
);
  alu_op_e      op;
  logic         is_arith, as_sub, as_dec, as_cin;
  logic [W-1:0] arith_sum, logic_res, shift_res;
  logic         arith_c, arith_v, shift_c;
  logic [W-1:0] flag_src;
  logic         n_raw, z_raw, c_raw, v_raw;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign as_sub   = (op == OP_SUB) || (op == OP_CMP);
  // compare is always binary with no borrow in
  assign as_dec   = dec_i && is_arith;
  assign as_cin   = (op == OP_CMP) ? 1'b1 : carry_i;

  acc_alu_addsub #(.DIGITS(DIGITS)) i_addsub (
    .a_i   (acc_i),
    .b_i   (mem_i),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .dec_i (as_dec),
    .sum_o (arith_sum),
    .cout_o(arith_c),
    .ovf_o (arith_v)
  );

  acc_alu_logic #(.W(W)) i_logic (
    .op_i (op),
    .a_i  (acc_i),
    .m_i  (mem_i),
    .res_o(logic_res)
  );

  acc_alu_shift #(.W(W)) i_shift (
    .op_i  (op),
    .a_i   (acc_i),
    .cin_i (carry_i),
    .res_o (shift_res),
    .cout_o(shift_c)
  );

  always_comb begin
    res_o    = acc_i;
    flag_src = acc_i;
    c_raw    = 1'b0;
    v_raw    = 1'b0;
    upd_o    = MASK_NONE;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_o    = arith_sum;
        flag_src = arith_sum;
        c_raw    = arith_c;
        v_raw    = arith_v;
        upd_o    = MASK_ALL;
      end
      OP_CMP: begin
        flag_src = arith_sum;
        c_raw    = arith_c;
        upd_o    = MASK_NZC;
      end
      OP_BIT: begin
        flag_src = logic_res;
        v_raw    = mem_i[W-2];
        upd_o    = MASK_NZV;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_PASS: begin
        res_o    = logic_res;
        flag_src = logic_res;
        upd_o    = MASK_NZ;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_o    = shift_res;
        flag_src = shift_res;
        c_raw    = shift_c;
        upd_o    = MASK_NZC;
      end
      default: ;
    endcase
  end

  assign n_raw = (op == OP_BIT) ? mem_i[W-1] : flag_src[W-1];
  assign z_raw = (flag_src == '0);

  assign n_o = upd_o[FLAG_N] & n_raw;
  assign z_o = upd_o[FLAG_Z] & z_raw;
  assign c_o = upd_o[FLAG_C] & c_raw;
  assign v_o = upd_o[FLAG_V] & v_raw;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] mem_i,
  input logic         carry_i,
  input logic         dec_i,
  input logic [W-1:0] res_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_o,
  input logic         v_o,
  input logic [3:0]   upd_o
);
  logic [W:0] add_full;
  assign add_full = {1'b0, acc_i} + {1'b0, mem_i} + {{W{1'b0}}, carry_i};

  always_comb begin
    if (op_i == 4'd0 && !dec_i)
      p_add_ovf_r1: assert (v_o == ((acc_i[W-1] == mem_i[W-1]) && (res_o[W-1] != acc_i[W-1])
                                    && add_full[W-1:0] == res_o));
    if (op_i == 4'd9)
      p_shl_carry_r8: assert (c_o == acc_i[W-1] && res_o[0] == 1'b0);
    if (op_i == 4'd10)
      p_shr_carry_r8: assert (c_o == acc_i[0] && res_o[W-1] == 1'b0);
    if (op_i == 4'd11)
      p_rol_fill_r9: assert (res_o[0] == carry_i && c_o == acc_i[W-1]);
    if (op_i == 4'd12)
      p_ror_fill_r9: assert (res_o[W-1] == carry_i && c_o == acc_i[0]);
    if (op_i == 4'd5)
      p_cmp_keep_r10: assert (res_o == acc_i && c_o == (acc_i >= mem_i) && !v_o);
    if (op_i == 4'd6)
      p_bit_copy_r11: assert (res_o == acc_i && n_o == mem_i[W-1] && v_o == mem_i[W-2]
                              && z_o == ((acc_i & mem_i) == '0));
    if (upd_o[3] && op_i != 4'd5 && op_i != 4'd6)
      p_nz_track_r12: assert (n_o == res_o[W-1] && z_o == (res_o == '0));
    p_masked_low_r13: assert (((~upd_o) & {n_o, z_o, c_o, v_o}) == 4'b0000);
    if (op_i >= 4'd14)
      p_unused_r14: assert (upd_o == 4'b0000 && res_o == acc_i);
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) i_acc_alu_chk (
  .op_i   (op_i),
  .acc_i  (acc_i),
  .mem_i  (mem_i),
  .carry_i(carry_i),
  .dec_i  (dec_i),
  .res_o  (res_o),
  .n_o    (n_o),
  .z_o    (z_o),
  .c_o    (c_o),
  .v_o    (v_o),
  .upd_o  (upd_o)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'h00, mem_i = 8'h00;
  logic       carry_i = 1'b0, dec_i = 1'b0;
  logic [7:0] res_o;
  logic       n_o, z_o, c_o, v_o;
  logic [3:0] upd_o;
  int         n_checks = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  acc_alu i_acc_alu (
    .op_i(op_i), .acc_i(acc_i), .mem_i(mem_i), .carry_i(carry_i), .dec_i(dec_i),
    .res_o(res_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o), .upd_o(upd_o)
  );

  // expected {res[15:8], n, z, c, v, mask[3:0]}
  function automatic logic [15:0] model(int op, logic [7:0] a, logic [7:0] m, logic c, logic d);
    int r = a; logic nf, zf, cf = 0, vf = 0; logic [3:0] mk = 4'b0000;
    int zsrc, lo, hi; logic lc, hc; logic [8:0] s; logic [7:0] mm;
    zsrc = -1;
    case (op)
      0, 1: begin
        mm = (op == 1) ? ~m : m;
        s  = {1'b0, a} + {1'b0, mm} + {8'b0, c};
        vf = (a[7] == mm[7]) && (s[7] != a[7]);
        mk = 4'b1111;
        if (!d) begin r = s[7:0]; cf = s[8]; end
        else if (op == 0) begin
          lo = a % 16 + m % 16 + int'(c); lc = lo > 9; if (lc) lo += 6;
          hi = a / 16 + m / 16 + int'(lc); hc = hi > 9; if (hc) hi += 6;
          r = (hi & 15) * 16 + (lo & 15); cf = hc;
        end else begin
          lo = a % 16 - m % 16 - (1 - int'(c)); lc = lo < 0; if (lc) lo -= 6;
          hi = a / 16 - m / 16 - int'(lc); hc = hi < 0; if (hc) hi -= 6;
          r = (hi & 15) * 16 + (lo & 15); cf = !hc;
        end
      end
      2: begin r = a & m; mk = 4'b1100; end
      3: begin r = a | m; mk = 4'b1100; end
      4: begin r = a ^ m; mk = 4'b1100; end
      5: begin zsrc = (int'(a) - int'(m)) & 255; cf = a >= m; mk = 4'b1110; end
      6: begin zsrc = a & m; vf = m[6]; mk = 4'b1101; end
      7: begin r = (m + 1) & 255; mk = 4'b1100; end
      8: begin r = (int'(m) + 255) & 255; mk = 4'b1100; end
      9: begin r = (a * 2) & 255; cf = a[7]; mk = 4'b1110; end
      10: begin r = a / 2; cf = a[0]; mk = 4'b1110; end
      11: begin r = ((a * 2) & 255) + int'(c); cf = a[7]; mk = 4'b1110; end
      12: begin r = a / 2 + 128 * int'(c); cf = a[0]; mk = 4'b1110; end
      13: begin r = m; mk = 4'b1100; end
      default: ;
    endcase
    if (zsrc < 0) zsrc = r;
    nf = (op == 6) ? m[7] : zsrc[7];
    zf = (zsrc == 0);
    nf &= mk[3]; zf &= mk[2]; cf &= mk[1]; vf &= mk[0];
    return {r[7:0], nf, zf, cf, vf, mk};
  endfunction

  function automatic string tag_of(int op, logic d);
    case (op)
      0: return d ? "R3" : "R1";
      1: return d ? "R4" : "R2";
      2, 3, 4: return "R6";
      5: return "R10";
      6: return "R11";
      7, 8, 13: return "R7";
      9, 10: return "R8";
      11, 12: return "R9";
      default: return "R14";
    endcase
  endfunction

  task automatic check(string tag, int op, logic [7:0] a, logic [7:0] m, logic c, logic d);
    logic [15:0] exp_v, act_v;
    @(posedge clk); #1;
    op_i = op[3:0]; acc_i = a; mem_i = m; carry_i = c; dec_i = d;
    @(negedge clk);
    exp_v = model(op, a, m, c, d);
    act_v = {res_o, n_o, z_o, c_o, v_o, upd_o};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h m=%h c=%b d=%b: actual res=%h nzcv=%b mask=%b expected res=%h nzcv=%b mask=%b",
               tag, op, a, m, c, d, act_v[15:8], act_v[7:4], act_v[3:0],
               exp_v[15:8], exp_v[7:4], exp_v[3:0]);
    end
  endtask

  task automatic t_idle();
    check("R12", 0, 8'h00, 8'h00, 0, 0);
    check("R13", 14, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic t_bin_add();
    check("R1", 0, 8'h50, 8'h50, 0, 0);
    check("R1", 0, 8'hff, 8'h00, 1, 0);
    check("R1", 0, 8'h90, 8'h90, 0, 0);
    check("R1", 0, 8'h12, 8'h34, 1, 0);
  endtask

  task automatic t_bin_sub();
    check("R2", 1, 8'h05, 8'h03, 1, 0);
    check("R2", 1, 8'h05, 8'h05, 0, 0);
    check("R2", 1, 8'h80, 8'h01, 1, 0);
    check("R2", 1, 8'h00, 8'h01, 1, 0);
  endtask

  task automatic t_dec_add();
    check("R3", 0, 8'h45, 8'h38, 0, 1);
    check("R3", 0, 8'h99, 8'h01, 0, 1);
    check("R3", 0, 8'h58, 8'h46, 1, 1);
    check("R5", 0, 8'h79, 8'h00, 1, 1);
  endtask

  task automatic t_dec_sub();
    check("R4", 1, 8'h42, 8'h13, 1, 1);
    check("R4", 1, 8'h00, 8'h01, 1, 1);
    check("R4", 1, 8'h50, 8'h50, 0, 1);
    check("R5", 1, 8'h80, 8'h01, 1, 1);
  endtask

  task automatic t_logic();
    check("R6", 2, 8'hf0, 8'h0f, 1, 1);
    check("R6", 3, 8'h80, 8'h01, 0, 0);
    check("R6", 4, 8'haa, 8'haa, 1, 0);
    check("R7", 7, 8'h12, 8'hff, 0, 0);
    check("R7", 8, 8'h12, 8'h00, 1, 0);
    check("R7", 13, 8'h12, 8'h80, 0, 1);
  endtask

  task automatic t_shift();
    check("R8", 9, 8'h81, 8'h00, 1, 0);
    check("R8", 10, 8'h01, 8'h00, 1, 0);
    check("R9", 11, 8'h80, 8'h00, 1, 0);
    check("R9", 12, 8'h01, 8'h00, 1, 0);
    check("R9", 12, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic t_compare();
    check("R10", 5, 8'h40, 8'h40, 0, 1);
    check("R10", 5, 8'h10, 8'h20, 1, 0);
    check("R10", 5, 8'h20, 8'h10, 0, 1);
  endtask

  task automatic t_bit();
    check("R11", 6, 8'h0f, 8'hc0, 0, 0);
    check("R11", 6, 8'h41, 8'h41, 1, 0);
  endtask

  task automatic t_unused();
    check("R14", 14, 8'h5a, 8'hff, 1, 1);
    check("R14", 15, 8'h80, 8'h00, 1, 0);
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr = 16'hace1;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 24; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        check(tag_of(op, lfsr[1]), op, lfsr[15:8], lfsr[7:0] ^ 8'h5c, lfsr[0], lfsr[1]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_bin_add();
    t_bin_sub();
    t_dec_add();
    t_dec_sub();
    t_logic();
    t_shift();
    t_compare();
    t_bit();
    t_unused();
    t_sweep();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule